// File: doc/BRIEF.md
# Outstanding Request Entry Writer with Completion Span Prediction

This block sits on the outbound side of a transaction-layer request path. Each time a read or write request header leaves the device, the block fills one entry of a tag-indexed table. Each entry holds what a later completion check needs: a valid bit, the requester ID, the full 8-bit tag, the raw 16-byte header, and two predicted fields. The predicted fields are the byte count the completion must report and the 7-bit lower address it must carry.

Both predictions come from the header. The byte count follows from the first and last byte-enable nibbles and the length in DW. The low two address bits come from the first byte-enable nibble. The upper five come from the request address byte, whose position depends on whether the header is 3 or 4 DW. The prediction logic is combinational and lands in the table on the same clock as the request strobe. A registered read port lets the neighbouring completion checker fetch an entry by index. A one-cycle warning pulse reports when a request overwrites an entry that is still valid.

The header is taken as 128 bits with byte 0 in bits [127:120]. The fields used are: format in byte 0 bits [6:5], length in {byte 2 bits [1:0], byte 3}, requester ID in bytes 4–5, tag in byte 6, and the byte enables in byte 7 (last nibble [7:4], first nibble [3:0]). Byte 11 sits in bits [39:32] and byte 15 in bits [7:0].

Top module: `req_scoreboard_fill`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rd_valid` and `ovw_warn` are 0. Every table entry reads back as invalid until it is written again.
- R2: When the last byte-enable nibble is 0 and the first is not, the predicted byte count is 1 for first-enable values 0x1/0x2/0x4/0x8, 2 for 0x3/0x6/0xC, 4 for 0x9/0xB/0xD/0xF and 3 for 0x5/0x7/0xA/0xE.
- R3: Predicted lower address bits [1:0] equal the count of zero bits below the lowest set bit of the first byte-enable nibble, taken modulo 4 (a first nibble of 0 gives 0).
- R4: When the last byte-enable nibble is nonzero, the predicted byte count is length×4, minus the trailing-zero count of the first nibble (4 if that nibble is 0), minus the number of zero bits above the highest set bit of the last nibble. The last deduction is left out when the length field equals 1.
- R5: When all eight byte-enable bits are 0, the predicted byte count is 1 and lower address bits [1:0] are 0.
- R6: Predicted lower address bits [6:2] are bits [6:2] of header byte 15 when format bit 0 is 1 (4-DW header, format 1 or 3), and of byte 11 otherwise.
- R7: A length field of 0 means 1024 DW. The byte count is 12 bits wide, so a full 4096-byte span reads as 0.
- R8: A cycle with `req_valid` high stores valid=1 with the requester ID, full tag, raw header and both predictions in the entry indexed by the low IDX_W tag bits. `rd_*` shows the entry selected by `rd_idx` one cycle later, with its contents before any write at that same edge.
- R9: A write to an entry that is already valid raises `ovw_warn` for exactly one cycle, on the cycle after the write, with `ovw_idx` giving that entry's index. A write to an invalid entry leaves `ovw_warn` at 0.
- R10: A cycle with `req_valid` low changes no entry and gives no warning, whatever is on `req_hdr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Outbound request header present this cycle |
| req_hdr | input | 128 | Raw request header, byte 0 in the top bits |
| rd_idx | input | IDX_W | Table index to read |
| rd_valid | output | 1 | Valid bit of the read entry |
| rd_req_id | output | 16 | Stored requester ID |
| rd_tag | output | 8 | Stored full tag |
| rd_bc | output | 12 | Stored predicted byte count |
| rd_la | output | 7 | Stored predicted lower address |
| rd_hdr | output | 128 | Stored raw header |
| ovw_warn | output | 1 | Pulse: a write hit an entry that was still valid |
| ovw_idx | output | IDX_W | Index of the entry that was overwritten |

## Verification
The bench builds the block with IDX_W=3, so the table has eight entries. With eight entries, tags that differ only above bit 2 alias onto the same entry. This exposes both the overwrite warning and the storing of the full tag separate from the index, and the bench can read every entry after a reset within a few cycles. The header width is fixed, so every byte-enable pair, the length values 0, 1 and 2 and above, and all four format codes can be driven directly at that size.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int HDR_BYTES = 16;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int BC_W      = 12;
  localparam int LA_W      = 7;
  localparam int LEN_W     = 10;
  localparam int RID_W     = 16;
  localparam int TAG_W     = 8;

  typedef struct packed {
    logic [RID_W-1:0] req_id;
    logic [TAG_W-1:0] tag;
    logic [BC_W-1:0]  bc;
    logic [LA_W-1:0]  la;
    logic [HDR_W-1:0] hdr;
  } sb_entry_t;

  localparam int ENTRY_W = $bits(sb_entry_t);

  function automatic logic [7:0] hdr_byte(input logic [HDR_W-1:0] h, input int n);
    return h[HDR_W-1-8*n -: 8];
  endfunction
endpackage

// File: rtl/be_span_calc.sv
module be_span_calc
  import sbw_pkg::*;
(
  input  logic [3:0]       first_be,
  input  logic [3:0]       last_be,
  input  logic [LEN_W-1:0] len,
  output logic [BC_W-1:0]  bc,
  output logic [1:0]       la_lo
);
  localparam int DW_W   = LEN_W + 1;
  localparam int SPAN_W = DW_W + 2;

  logic [2:0]        tz_first;
  logic [1:0]        lz_last;
  logic [DW_W-1:0]   len_dw;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] cut_hi;

  always_comb begin
    casez (first_be)
      4'b???1: tz_first = 3'd0;
      4'b??10: tz_first = 3'd1;
      4'b?100: tz_first = 3'd2;
      4'b1000: tz_first = 3'd3;
      default: tz_first = 3'd4;
    endcase
  end

  always_comb begin
    casez (last_be)
      4'b1???: lz_last = 2'd0;
      4'b01??: lz_last = 2'd1;
      4'b001?: lz_last = 2'd2;
      4'b0001: lz_last = 2'd3;
      default: lz_last = 2'd0;
    endcase
  end

  assign len_dw = (len == '0) ? DW_W'(1 << LEN_W) : {1'b0, len};
  assign cut_hi = (len == LEN_W'(1)) ? '0 : SPAN_W'(lz_last);
  assign span   = {len_dw, 2'b00} - SPAN_W'(tz_first) - cut_hi;

  always_comb begin
    if ({last_be, first_be} == 8'h00) begin
      bc = BC_W'(1);
    end else if (last_be == 4'h0) begin
      case (first_be)
        4'h1, 4'h2, 4'h4, 4'h8: bc = BC_W'(1);
        4'h3, 4'h6, 4'hC:       bc = BC_W'(2);
        4'h9, 4'hB, 4'hD, 4'hF: bc = BC_W'(4);
        default:                bc = BC_W'(3);
      endcase
    end else begin
      bc = span[BC_W-1:0];
    end
  end

  assign la_lo = tz_first[1:0];
endmodule

// File: rtl/lo_addr_pick.sv
module lo_addr_pick
  import sbw_pkg::*;
(
  input  logic [1:0]       fmt,
  input  logic [HDR_W-1:0] hdr,
  output logic [4:0]       la_hi
);
  localparam int BYTE_3DW = 11;
  localparam int BYTE_4DW = 15;

  logic [7:0] b_3dw;
  logic [7:0] b_4dw;

  assign b_3dw = hdr_byte(hdr, BYTE_3DW);
  assign b_4dw = hdr_byte(hdr, BYTE_4DW);
  assign la_hi = fmt[0] ? b_4dw[6:2] : b_3dw[6:2];
endmodule

// File: rtl/sb_entry_ram.sv
module sb_entry_ram
  import sbw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   wa,
  input  sb_entry_t          wd,
  input  logic [IDX_W-1:0]   ra,
  output sb_entry_t          rd,
  output logic               rd_vld,
  output logic               ovw,
  output logic [IDX_W-1:0]   ovw_at
);
  localparam int DEPTH = 1 << IDX_W;

  sb_entry_t        mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
      ovw    <= 1'b0;
      ovw_at <= '0;
    end else begin
      rd_vld <= vld[ra];
      ovw    <= we && vld[wa];
      if (we) begin
        vld[wa] <= 1'b1;
        ovw_at  <= wa;
      end
    end
  end
endmodule

// File: rtl/req_scoreboard_fill.sv
module req_scoreboard_fill
  import sbw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [127:0]      req_hdr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [15:0]       rd_req_id,
  output logic [7:0]        rd_tag,
  output logic [11:0]       rd_bc,
  output logic [6:0]        rd_la,
  output logic [127:0]      rd_hdr,
  output logic              ovw_warn,
  output logic [IDX_W-1:0]  ovw_idx
);
  logic [1:0]       f_fmt;
  logic [LEN_W-1:0] f_len;
  logic [3:0]       f_first;
  logic [3:0]       f_last;
  logic [1:0]       exp_la_lo;
  logic [4:0]       exp_la_hi;
  logic [BC_W-1:0]  exp_bc;
  logic [LA_W-1:0]  exp_la;
  sb_entry_t        wr_ent;
  sb_entry_t        rd_ent;

  assign f_fmt   = hdr_byte(req_hdr, 0) >> 5;
  assign f_len   = {hdr_byte(req_hdr, 2), hdr_byte(req_hdr, 3)} & {{(16-LEN_W){1'b0}}, {LEN_W{1'b1}}};
  assign f_last  = hdr_byte(req_hdr, 7) >> 4;
  assign f_first = hdr_byte(req_hdr, 7) & 8'h0F;

  be_span_calc u_span (
    .first_be (f_first),
    .last_be  (f_last),
    .len      (f_len),
    .bc       (exp_bc),
    .la_lo    (exp_la_lo)
  );

  lo_addr_pick u_la (
    .fmt   (f_fmt),
    .hdr   (req_hdr),
    .la_hi (exp_la_hi)
  );

  assign exp_la = {exp_la_hi, exp_la_lo};

  always_comb begin
    wr_ent.req_id = {hdr_byte(req_hdr, 4), hdr_byte(req_hdr, 5)};
    wr_ent.tag    = hdr_byte(req_hdr, 6);
    wr_ent.bc     = exp_bc;
    wr_ent.la     = exp_la;
    wr_ent.hdr    = req_hdr;
  end

  sb_entry_ram #(.IDX_W(IDX_W)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (req_valid),
    .wa     (wr_ent.tag[IDX_W-1:0]),
    .wd     (wr_ent),
    .ra     (rd_idx),
    .rd     (rd_ent),
    .rd_vld (rd_valid),
    .ovw    (ovw_warn),
    .ovw_at (ovw_idx)
  );

  assign rd_req_id = rd_ent.req_id;
  assign rd_tag    = rd_ent.tag;
  assign rd_bc     = rd_ent.bc;
  assign rd_la     = rd_ent.la;
  assign rd_hdr    = rd_ent.hdr;
endmodule

// File: rtl/req_scoreboard_fill_chk.sv
module req_scoreboard_fill_chk (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic [127:0] req_hdr,
  input logic [11:0]  exp_bc,
  input logic [6:0]   exp_la,
  input logic         rd_valid,
  input logic         ovw_warn
);
  logic [3:0] c_first;
  logic [3:0] c_last;
  logic [9:0] c_len;

  assign c_first = req_hdr[67:64];
  assign c_last  = req_hdr[71:68];
  assign c_len   = req_hdr[105:96];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !ovw_warn));

  // R2
  single_dw_range_chk: assert property (@(posedge clk) disable iff (rst)
    (c_last == 4'h0) |-> (exp_bc >= 12'd1 && exp_bc <= 12'd4));

  // R3
  aligned_first_chk: assert property (@(posedge clk) disable iff (rst)
    c_first[0] |-> (exp_la[1:0] == 2'd0));

  // R4
  one_dw_full_chk: assert property (@(posedge clk) disable iff (rst)
    (c_first == 4'hF && c_last != 4'h0 && c_len == 10'd1) |-> (exp_bc == 12'd4));

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ({c_last, c_first} == 8'h00) |-> (exp_bc == 12'd1 && exp_la[1:0] == 2'd0));

  // R7
  max_span_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (c_len == 10'd0 && c_first == 4'hF && c_last == 4'hF) |-> (exp_bc == 12'd0));

  // R9
  warn_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovw_warn |-> $past(req_valid));

  // R10
  idle_no_warn_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !ovw_warn);
endmodule

bind req_scoreboard_fill req_scoreboard_fill_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_hdr   (req_hdr),
  .exp_bc    (exp_bc),
  .exp_la    (exp_la),
  .rd_valid  (rd_valid),
  .ovw_warn  (ovw_warn)
);

// File: tb/sim_req_scoreboard_fill.sv
`timescale 1ns/1ps
module sim_req_scoreboard_fill;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [127:0]     req_hdr = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic             rd_valid;
  logic [15:0]      rd_req_id;
  logic [7:0]       rd_tag;
  logic [11:0]      rd_bc;
  logic [6:0]       rd_la;
  logic [127:0]     rd_hdr;
  logic             ovw_warn;
  logic [IDX_W-1:0] ovw_idx;

  int errors = 0;
  int checks = 0;

  logic         m_vld [DEPTH];
  logic [15:0]  m_id  [DEPTH];
  logic [7:0]   m_tag [DEPTH];
  logic [11:0]  m_bc  [DEPTH];
  logic [6:0]   m_la  [DEPTH];
  logic [127:0] m_hdr [DEPTH];

  logic         e_vld, e_warn;
  logic [IDX_W-1:0] e_widx;
  logic [15:0]  e_id;
  logic [7:0]   e_tag;
  logic [11:0]  e_bc;
  logic [6:0]   e_la;
  logic [127:0] e_hdr;

  always #5 clk = ~clk;

  req_scoreboard_fill #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hdr(req_hdr), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_req_id(rd_req_id), .rd_tag(rd_tag), .rd_bc(rd_bc),
    .rd_la(rd_la), .rd_hdr(rd_hdr), .ovw_warn(ovw_warn), .ovw_idx(ovw_idx)
  );

  function automatic logic [127:0] mk_hdr(input int fmt, input int len, input int id,
                                          input int tag, input int lbe, input int fbe,
                                          input int b11, input int b15);
    logic [7:0] b [16];
    logic [127:0] h;
    for (int i = 0; i < 16; i++) b[i] = 8'(8'h30 + i);
    b[0]  = 8'(fmt << 5);
    b[2]  = 8'((len >> 8) & 3) | 8'h40;
    b[3]  = 8'(len & 255);
    b[4]  = 8'(id >> 8);
    b[5]  = 8'(id & 255);
    b[6]  = 8'(tag);
    b[7]  = 8'((lbe << 4) | fbe);
    b[11] = 8'(b11);
    b[15] = 8'(b15);
    for (int i = 0; i < 16; i++) h[127-8*i -: 8] = b[i];
    return h;
  endfunction

  function automatic int tz4(input int v);
    int n = 0;
    while (n < 4 && ((v >> n) & 1) == 0) n++;
    return n;
  endfunction

  function automatic int ref_bc(input int fbe, input int lbe, input int len);
    int dw, ones, lz;
    if (fbe == 0 && lbe == 0) return 1;
    if (lbe == 0) begin
      ones = 0;
      for (int i = 0; i < 4; i++) ones += (fbe >> i) & 1;
      if (ones == 1) return 1;
      if (fbe == 3 || fbe == 6 || fbe == 12) return 2;
      if ((fbe & 1) && (fbe & 8)) return 4;
      return 3;
    end
    dw = (len == 0) ? 1024 : len;
    lz = 0;
    if (len != 1) begin
      int k = 3;
      while (((lbe >> k) & 1) == 0) begin lz++; k--; end
    end
    return (dw * 4 - tz4(fbe) - lz) % 4096;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [127:0] h, input int ri, input string req);
    int wi, fbe, lbe, len, fmt;
    req_valid = v; req_hdr = h; rd_idx = IDX_W'(ri);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
      e_vld = 1'b0; e_warn = 1'b0;
    end else begin
      e_vld = m_vld[ri]; e_id = m_id[ri]; e_tag = m_tag[ri];
      e_bc = m_bc[ri]; e_la = m_la[ri]; e_hdr = m_hdr[ri];
      wi = h[72 +: IDX_W];
      e_warn = v && m_vld[wi];
      e_widx = IDX_W'(wi);
      if (v) begin
        fbe = h[67:64]; lbe = h[71:68]; len = h[105:96]; fmt = h[126:125];
        m_vld[wi] = 1'b1;
        m_id[wi]  = h[95:80];
        m_tag[wi] = h[79:72];
        m_hdr[wi] = h;
        m_bc[wi]  = 12'(ref_bc(fbe, lbe, len));
        m_la[wi]  = {(fmt & 1) ? h[6:2] : h[38:34], 2'(tz4(fbe) % 4)};
      end
    end
    @(negedge clk);
    chk(rd_valid === e_vld, req, "rd_valid", 128'(rd_valid), 128'(e_vld));
    chk(ovw_warn === e_warn, req, "ovw_warn", 128'(ovw_warn), 128'(e_warn));
    if (e_warn) chk(ovw_idx === e_widx, req, "ovw_idx", 128'(ovw_idx), 128'(e_widx));
    if (e_vld) begin
      chk(rd_bc === e_bc, req, "rd_bc", 128'(rd_bc), 128'(e_bc));
      chk(rd_la === e_la, req, "rd_la", 128'(rd_la), 128'(e_la));
      chk(rd_req_id === e_id, req, "rd_req_id", 128'(rd_req_id), 128'(e_id));
      chk(rd_tag === e_tag, req, "rd_tag", 128'(rd_tag), 128'(e_tag));
      chk(rd_hdr === e_hdr, req, "rd_hdr", rd_hdr, e_hdr);
    end
  endtask

  task automatic wr_rd(input logic [127:0] h, input string req);
    int wi = h[72 +: IDX_W];
    step(1'b1, h, wi, req);
    step(1'b0, 128'h0, wi, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, '0, 0, "R1");
    step(1'b1, mk_hdr(0, 1, 16'h1111, 1, 0, 15, 0, 0), 1, "R1");
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, i, "R1");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();
    // R8: basic stores and readback, plus read-first behaviour on the same index
    wr_rd(mk_hdr(0, 2, 16'hBEEF, 8'h02, 4'hF, 4'hF, 8'h44, 8'h00), "R8");
    step(1'b1, mk_hdr(1, 3, 16'h0102, 8'h03, 4'h1, 4'hE, 8'h00, 8'h7C), 3, "R8");
    step(1'b0, '0, 3, "R8");
    // R2 and R3: single DW, every first-enable pattern (0 falls under R5)
    for (int f = 0; f < 16; f++)
      wr_rd(mk_hdr(0, 1, 16'h2000 + f, 8'h40 | (f % DEPTH), 0, f, 8'h28, 0),
            f == 0 ? "R5" : "R2/R3");
    // R4: multi-DW with sparse enables
    for (int l = 1; l < 16; l++)
      wr_rd(mk_hdr(2, 5, 16'h3000 + l, 8'h80 | (l % DEPTH), l, (l * 7) % 16, 8'h7F, 0), "R4");
    // R4: length 1, last nibble nonzero, last deduction skipped
    wr_rd(mk_hdr(0, 1, 16'h3100, 8'h05, 4'h2, 4'h4, 8'h10, 0), "R4");
    wr_rd(mk_hdr(0, 1, 16'h3101, 8'h06, 4'h1, 4'h0, 8'h10, 0), "R4");
    // R5: first nibble zero with last nonzero counts 4 trailing zeros
    wr_rd(mk_hdr(0, 2, 16'h3200, 8'h07, 4'hF, 4'h0, 8'h10, 0), "R5/R4");
    // R7: length 0 means 1024 DW
    wr_rd(mk_hdr(0, 0, 16'h4000, 8'h00, 4'hF, 4'hF, 8'h00, 0), "R7");
    wr_rd(mk_hdr(0, 0, 16'h4001, 8'h01, 4'h1, 4'h2, 8'h00, 0), "R7");
    // R6: all four format codes, distinct bytes 11 and 15
    for (int fm = 0; fm < 4; fm++)
      wr_rd(mk_hdr(fm, 1, 16'h5000 + fm, 8'h10 | fm, 0, 4'hF, 8'h54, 8'h2B), "R6");
    // R9: writes to already valid entries, aliasing tags
    step(1'b1, mk_hdr(0, 1, 16'h6000, 8'hF3, 0, 4'h1, 8'h0C, 0), 3, "R9");
    step(1'b1, mk_hdr(0, 1, 16'h6001, 8'h0B, 0, 4'h2, 8'h0C, 0), 3, "R9");
    step(1'b0, '0, 3, "R9");
    // R10: idle cycles with garbage header change nothing
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, {4{32'hDEAD_BEEF}} ^ 128'(i), i, "R10");
    // R1: reset in the middle clears everything, then writes into an invalid entry give no warning
    do_reset();
    wr_rd(mk_hdr(3, 8, 16'h7000, 8'hE4, 4'h7, 4'h8, 8'h00, 8'h64), "R9");
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, i, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule